// File: doc/BRIEF.md
# Byte-Serial Register/Memory Move Decoder

This block takes the encoded bytes of a 16-bit-mode register/memory move, one byte per cycle over a valid/ready handshake. It splits the leading byte into an operation code, a direction bit and a width bit. It splits the addressing byte into its mode, register and register/memory fields. From those two bytes it works out how many address-offset bytes and data bytes follow, and it collects them. When the last byte is taken, it presents the whole decoded record for one cycle and raises a completion pulse.

A front end feeds the decoder from an instruction byte stream. The decoded record then drives an address unit and a register file. The decoder does not form the effective address itself. It reports which base and index registers take part, and each comes with its own valid bit. The select codes use the word-register numbering: BX=3, BP=5, SI=6, DI=7.

Top module: `modrm_decoder`

## Requirements
- R1: In the first accepted byte, bits 7:2 appear on `opcode_f`, bit 1 on `dir_f` and bit 0 on `wide_f` (1 = word, 0 = byte).
- R2: In the second accepted byte, bits 7:6 appear on `mod_f`, bits 5:3 on `reg_f` and bits 2:0 on `rm_f`.
- R3: With mode 11, `is_mem`, `base_vld` and `index_vld` are 0, no offset bytes are taken and `disp` is 0.
- R4: With modes 00, 01 and 10, `is_mem` is 1. The rm field maps as follows: 000 gives BX+SI, 001 gives BX+DI, 010 gives BP+SI, 011 gives BP+DI, 100 gives SI alone, 101 gives DI alone, 110 gives BP alone and 111 gives BX alone. Base codes are BX=3 and BP=5; index codes are SI=6 and DI=7.
- R5: Mode 00 with rm 110 is the direct form. `is_direct` is 1, neither register valid bit is set, and two offset bytes follow (low byte first) that form the absolute address on `disp`.
- R6: Mode 01 takes one offset byte and sign-extends it to 16 bits on `disp`. Mode 00, apart from the direct form, takes none.
- R7: Mode 10 takes two offset bytes, low byte first, onto `disp`.
- R8: When the first byte has bits 7:1 equal to 1100011, data bytes follow the offset bytes. There is one data byte, zero-extended on `imm`, when bit 0 is 0, and two data bytes, low byte first, when bit 0 is 1. Any other first byte takes no data bytes, and `imm` is 0.
- R9: `ilen` shows the number of bytes the instruction took, from 2 up to 6. A word store of immediate data through a 16-bit offset takes 6 bytes.
- R10: `done` is high for exactly one cycle, the cycle after the last byte is accepted. `in_ready` is low during that cycle, and the decoded outputs are valid in it. After it, the next byte accepted is a new first byte.
- R11: A cycle with `in_valid` low takes no byte, and the value on `in_byte` in that cycle has no effect on the result.
- R12: A synchronous `rst` abandons any partly taken instruction. After it, `done` is 0, `in_ready` is 1, and `ilen`, `opcode_f`, `disp`, `imm`, `is_mem`, `base_vld` and `index_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered |
| in_byte | input | 8 | Offered instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| done | output | 1 | One-cycle completion pulse |
| opcode_f | output | 6 | Operation code field |
| dir_f | output | 1 | Direction bit |
| wide_f | output | 1 | Width bit |
| mod_f | output | 2 | Mode field |
| reg_f | output | 3 | Register field |
| rm_f | output | 3 | Register/memory field |
| is_mem | output | 1 | Operand is in memory |
| is_direct | output | 1 | Absolute-address form |
| base_vld | output | 1 | Base register is used |
| base_sel | output | 3 | Base register code |
| index_vld | output | 1 | Index register is used |
| index_sel | output | 3 | Index register code |
| disp | output | 16 | Address offset, sign-extended when it is one byte |
| imm | output | 16 | Immediate data |
| ilen | output | 3 | Bytes taken by the instruction |

## Verification
Some checks run on every cycle. They cover the width of the completion pulse, the ready line being low while `done` is high, the match between the counted length and the length implied by the mode and operation code, the absence of registers in the direct form, a zero offset in register mode, and the fact that idle cycles take nothing. Other behaviours can only be shown by scenarios. These are the rm-to-register table, the sign extension of a one-byte offset, the low-first byte order of offsets and data, the correctness of the captured values, and the clearing of a half-taken instruction by reset.

// File: rtl/modrm_pkg.sv
package modrm_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 3;

  typedef enum logic [2:0] {ST_OPC, ST_MODRM, ST_DISP, ST_IMM, ST_DONE} dec_state_e;

  localparam logic [2:0] SEL_BX = 3'd3;
  localparam logic [2:0] SEL_BP = 3'd5;
  localparam logic [2:0] SEL_SI = 3'd6;
  localparam logic [2:0] SEL_DI = 3'd7;

  // number of offset bytes implied by mode and rm
  function automatic logic [1:0] disp_count(input logic [1:0] m, input logic [2:0] r);
    unique case (m)
      2'b00:   return (r == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // number of data bytes implied by the leading byte
  function automatic logic [1:0] imm_count(input logic [BYTE_W-1:0] opc, input logic [6:0] code);
    if (opc[7:1] == code) return opc[0] ? 2'd2 : 2'd1;
    return 2'd0;
  endfunction

  // assemble a 0/1/2-byte little-endian value
  function automatic logic [WORD_W-1:0] join_bytes(input logic [1:0] n, input logic [BYTE_W-1:0] lo,
                                                   input logic [BYTE_W-1:0] hi, input logic sext);
    unique case (n)
      2'd1:    return sext ? {{BYTE_W{lo[BYTE_W-1]}}, lo} : {{BYTE_W{1'b0}}, lo};
      2'd2:    return {hi, lo};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/modrm_field_map.sv
module modrm_field_map
  import modrm_pkg::*;
(
  input  logic       have_modrm,
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  output logic       is_mem,
  output logic       is_direct,
  output logic       base_vld,
  output logic [2:0] base_sel,
  output logic       index_vld,
  output logic [2:0] index_sel
);
  always_comb begin
    is_mem    = have_modrm && (mod_i != 2'b11);
    is_direct = is_mem && (mod_i == 2'b00) && (rm_i == 3'b110);
    base_vld  = 1'b0;
    base_sel  = '0;
    index_vld = 1'b0;
    index_sel = '0;
    if (is_mem && !is_direct) begin
      unique case (rm_i)
        3'b000: begin base_vld = 1'b1; base_sel = SEL_BX; index_vld = 1'b1; index_sel = SEL_SI; end
        3'b001: begin base_vld = 1'b1; base_sel = SEL_BX; index_vld = 1'b1; index_sel = SEL_DI; end
        3'b010: begin base_vld = 1'b1; base_sel = SEL_BP; index_vld = 1'b1; index_sel = SEL_SI; end
        3'b011: begin base_vld = 1'b1; base_sel = SEL_BP; index_vld = 1'b1; index_sel = SEL_DI; end
        3'b100: begin index_vld = 1'b1; index_sel = SEL_SI; end
        3'b101: begin index_vld = 1'b1; index_sel = SEL_DI; end
        3'b110: begin base_vld = 1'b1; base_sel = SEL_BP; end
        default: begin base_vld = 1'b1; base_sel = SEL_BX; end
      endcase
    end
  end
endmodule

// File: rtl/modrm_byte_seq.sv
module modrm_byte_seq
  import modrm_pkg::*;
#(
  parameter logic [6:0] IMM_OPCODE = 7'b1100011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              done,
  output logic [BYTE_W-1:0] opc_q,
  output logic [BYTE_W-1:0] modrm_q,
  output logic              have_modrm,
  output logic [BYTE_W-1:0] disp_lo,
  output logic [BYTE_W-1:0] disp_hi,
  output logic [BYTE_W-1:0] imm_lo,
  output logic [BYTE_W-1:0] imm_hi,
  output logic [LEN_W-1:0]  ilen
);
  dec_state_e state;
  logic       pos;
  logic       accept;
  logic [1:0] nd_new, nd_cur, ni_cur;
  logic       disp_last, imm_last;

  assign accept    = in_valid && in_ready;
  assign in_ready  = (state != ST_DONE);
  assign done      = (state == ST_DONE);
  assign nd_new    = disp_count(in_byte[7:6], in_byte[2:0]);
  assign nd_cur    = disp_count(modrm_q[7:6], modrm_q[2:0]);
  assign ni_cur    = imm_count(opc_q, IMM_OPCODE);
  assign disp_last = pos || (nd_cur == 2'd1);
  assign imm_last  = pos || (ni_cur == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPC; pos <= 1'b0; opc_q <= '0; modrm_q <= '0; have_modrm <= 1'b0;
      disp_lo <= '0; disp_hi <= '0; imm_lo <= '0; imm_hi <= '0; ilen <= '0;
    end else begin
      unique case (state)
        ST_OPC: if (accept) begin
          opc_q <= in_byte; modrm_q <= '0; have_modrm <= 1'b0;
          disp_lo <= '0; disp_hi <= '0; imm_lo <= '0; imm_hi <= '0;
          ilen <= LEN_W'(1); pos <= 1'b0; state <= ST_MODRM;
        end
        ST_MODRM: if (accept) begin
          modrm_q <= in_byte; have_modrm <= 1'b1; ilen <= ilen + LEN_W'(1); pos <= 1'b0;
          if (nd_new != 2'd0)      state <= ST_DISP;
          else if (ni_cur != 2'd0) state <= ST_IMM;
          else                     state <= ST_DONE;
        end
        ST_DISP: if (accept) begin
          if (pos) disp_hi <= in_byte; else disp_lo <= in_byte;
          ilen <= ilen + LEN_W'(1);
          if (disp_last) begin
            pos   <= 1'b0;
            state <= (ni_cur != 2'd0) ? ST_IMM : ST_DONE;
          end else pos <= 1'b1;
        end
        ST_IMM: if (accept) begin
          if (pos) imm_hi <= in_byte; else imm_lo <= in_byte;
          ilen <= ilen + LEN_W'(1);
          if (imm_last) begin pos <= 1'b0; state <= ST_DONE; end
          else pos <= 1'b1;
        end
        default: state <= ST_OPC;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10: no byte is offered as taken during the completion cycle
  p_ready_low_done_r10: assert property (@(posedge clk) disable iff (rst) done |-> !in_ready);
  // R11: an idle cycle inside an instruction leaves the byte count alone
  p_idle_no_take_r11: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && state != ST_OPC && state != ST_DONE) |=> $stable(ilen));
endmodule

// File: rtl/modrm_decoder.sv
module modrm_decoder
  import modrm_pkg::*;
#(
  parameter logic [6:0] IMM_OPCODE = 7'b1100011
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        done,
  output logic [5:0]  opcode_f,
  output logic        dir_f,
  output logic        wide_f,
  output logic [1:0]  mod_f,
  output logic [2:0]  reg_f,
  output logic [2:0]  rm_f,
  output logic        is_mem,
  output logic        is_direct,
  output logic        base_vld,
  output logic [2:0]  base_sel,
  output logic        index_vld,
  output logic [2:0]  index_sel,
  output logic [15:0] disp,
  output logic [15:0] imm,
  output logic [2:0]  ilen
);
  logic [BYTE_W-1:0] opc_q, modrm_q, disp_lo, disp_hi, imm_lo, imm_hi;
  logic              have_modrm;
  logic [1:0]        nd_w, ni_w;

  modrm_byte_seq #(.IMM_OPCODE(IMM_OPCODE)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .done(done), .opc_q(opc_q), .modrm_q(modrm_q),
    .have_modrm(have_modrm), .disp_lo(disp_lo), .disp_hi(disp_hi),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .ilen(ilen)
  );

  assign opcode_f = opc_q[7:2];
  assign dir_f    = opc_q[1];
  assign wide_f   = opc_q[0];
  assign mod_f    = modrm_q[7:6];
  assign reg_f    = modrm_q[5:3];
  assign rm_f     = modrm_q[2:0];

  modrm_field_map u_map (
    .have_modrm(have_modrm), .mod_i(modrm_q[7:6]), .rm_i(modrm_q[2:0]),
    .is_mem(is_mem), .is_direct(is_direct), .base_vld(base_vld), .base_sel(base_sel),
    .index_vld(index_vld), .index_sel(index_sel)
  );

  assign nd_w = have_modrm ? disp_count(modrm_q[7:6], modrm_q[2:0]) : 2'd0;
  assign ni_w = imm_count(opc_q, IMM_OPCODE);
  assign disp = join_bytes(nd_w, disp_lo, disp_hi, 1'b1);
  assign imm  = join_bytes(ni_w, imm_lo, imm_hi, 1'b0);

  // R9: counted length agrees with the length the fields imply
  p_len_match_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (ilen == (LEN_W'(2) + LEN_W'(nd_w) + LEN_W'(ni_w))));
  // R5: the absolute form names no register
  p_direct_no_regs_r5: assert property (@(posedge clk) disable iff (rst)
    is_direct |-> (!base_vld && !index_vld));
  // R3: register mode carries no offset
  p_regmode_no_disp_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !is_mem) |-> (disp == 16'h0000));
  // R4: a memory form always uses at least one register unless absolute
  p_mem_has_reg_r4: assert property (@(posedge clk) disable iff (rst)
    (done && is_mem && !is_direct) |-> (base_vld || index_vld));
endmodule

// File: tb/modrm_decoder_bench.sv
module modrm_decoder_bench;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, done, dir_f, wide_f, is_mem, is_direct, base_vld, index_vld;
  logic [5:0] opcode_f;
  logic [1:0] mod_f;
  logic [2:0] reg_f, rm_f, base_sel, index_sel, ilen;
  logic [15:0] disp, imm;

  modrm_decoder u_modrm_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .done(done), .opcode_f(opcode_f), .dir_f(dir_f), .wide_f(wide_f), .mod_f(mod_f),
    .reg_f(reg_f), .rm_f(rm_f), .is_mem(is_mem), .is_direct(is_direct),
    .base_vld(base_vld), .base_sel(base_sel), .index_vld(index_vld),
    .index_sel(index_sel), .disp(disp), .imm(imm), .ilen(ilen)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [7:0] b0, b1;
    logic bv, iv; logic [2:0] bs, is;
    logic [15:0] d, im; logic [2:0] len;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit prev_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic push_byte(input logic [7:0] b, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); in_valid = 1'b0; in_byte = 8'hFF - 8'(g);
    end
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // expected registers worked out from the rm table in the bench's own way
  task automatic send(input logic [7:0] bs[6], input int n, input logic [15:0] ed,
                      input logic [15:0] ei, input int gap);
    exp_t e;
    logic [1:0] m; logic [2:0] r; bit mem, dir;
    m = bs[1][7:6]; r = bs[1][2:0];
    mem = (m != 2'b11); dir = mem && m == 2'b00 && r == 3'b110;
    e.b0 = bs[0]; e.b1 = bs[1];
    e.bv = mem && !dir && r != 3'b100 && r != 3'b101;
    e.bs = e.bv ? ((r == 3'b010 || r == 3'b011 || r == 3'b110) ? 3'd5 : 3'd3) : 3'd0;
    e.iv = mem && r < 3'b110;
    e.is = e.iv ? (r[0] ? 3'd7 : 3'd6) : 3'd0;
    e.d = ed; e.im = ei; e.len = 3'(n);
    q.push_back(e);
    for (int k = 0; k < n; k++) push_byte(bs[k], (k % 2 == 1) ? gap : 0);
    @(negedge clk); in_valid = 1'b0;
  endtask

  // monitor: pop and compare on each completion pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) chk(1'b0, "R10 double done", 1, 0);
      if (done) begin
        chk(!in_ready, "R10 ready low in done", 32'(in_ready), 0);
        if (q.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(opcode_f == e.b0[7:2] && dir_f == e.b0[1] && wide_f == e.b0[0], "R1 opcode fields",
              {opcode_f, dir_f, wide_f}, e.b0);
          chk({mod_f, reg_f, rm_f} == e.b1, "R2 modrm fields", {mod_f, reg_f, rm_f}, e.b1);
          chk(is_mem == (e.b1[7:6] != 2'b11), "R3 is_mem", is_mem, e.b1[7:6] != 2'b11);
          chk(is_direct == (e.b1[7:6] == 2'b00 && e.b1[2:0] == 3'b110), "R5 is_direct", is_direct, 0);
          chk(base_vld == e.bv && base_sel == e.bs, "R4 base", {base_vld, base_sel}, {e.bv, e.bs});
          chk(index_vld == e.iv && index_sel == e.is, "R4 index", {index_vld, index_sel}, {e.iv, e.is});
          chk(disp == e.d, "R6 R7 disp", disp, e.d);
          chk(imm == e.im, "R8 imm", imm, e.im);
          chk(ilen == e.len, "R9 length", ilen, e.len);
        end
      end
      prev_done = done;
    end else prev_done = 1'b0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!done && in_ready && ilen == 0 && opcode_f == 0 && disp == 0 && imm == 0 && !is_mem
        && !base_vld && !index_vld, "R12 reset state", {done, in_ready, ilen}, 32'h010);

    send('{8'h8B, 8'hEC, 0, 0, 0, 0}, 2, 16'h0000, 16'h0000, 0);   // R3 register mode
    send('{8'h8A, 8'h15, 0, 0, 0, 0}, 2, 16'h0000, 16'h0000, 2);   // R4 [DI], R11 gaps
    send('{8'h88, 8'h16, 8'h00, 8'h10, 0, 0}, 4, 16'h1000, 16'h0000, 1); // R5 direct
    send('{8'h8A, 8'h45, 8'hFE, 0, 0, 0}, 3, 16'hFFFE, 16'h0000, 0); // R6 negative
    send('{8'h8A, 8'h45, 8'h02, 0, 0, 0}, 3, 16'h0002, 16'h0000, 3); // R6 positive
    send('{8'h8B, 8'h82, 8'h34, 8'h12, 0, 0}, 4, 16'h1234, 16'h0000, 0); // R7 BP+SI
    send('{8'hC7, 8'h87, 8'h00, 8'h10, 8'h34, 8'h12}, 6, 16'h1000, 16'h1234, 1); // R8 R9
    send('{8'hC6, 8'h06, 8'h00, 8'h20, 8'hAB, 0}, 5, 16'h2000, 16'h00AB, 0); // R8 byte imm
    send('{8'hC6, 8'hC3, 8'h7F, 0, 0, 0}, 3, 16'h0000, 16'h007F, 2); // R8 reg mode
    for (int r = 0; r < 8; r++)                                     // R4 full table
      send('{8'h8B, {2'b01, 3'b010, 3'(r)}, 8'h80, 0, 0, 0}, 3, 16'hFF80, 16'h0000, 0);
    send('{8'h89, 8'h07, 0, 0, 0, 0}, 2, 16'h0000, 16'h0000, 0);   // R4 mode 00 BX

    // R12: abandon a half-taken instruction
    push_byte(8'hC7, 0); push_byte(8'h87, 0); push_byte(8'h55, 0);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!done && in_ready && ilen == 0 && opcode_f == 0 && disp == 0 && imm == 0 && !is_mem
        && !base_vld && !index_vld, "R12 mid-instruction reset", {done, in_ready, ilen}, 32'h010);
    send('{8'h8B, 8'h1E, 8'h78, 8'h56, 0, 0}, 4, 16'h5678, 16'h0000, 0); // R12 fresh start

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 all completions seen", q.size(), 0);
    summary();
  end
endmodule